// File: doc/BRIEF.md
# Elastic Stereo Sample Buffer with Block Slip

This block carries stereo audio words from a write side to a read side. Each side has its own clock and its own sample strobe. Both run at the same nominal sample rate, but the write side may jitter and drift against the clean read side. The words sit in a dual-clock RAM. The read domain compares its own pointer with a Gray-synchronised copy of the write pointer to get a fill level. It then steers that fill toward half depth.

Small drifts produce frequency-trim pulses for an external oscillator. Large drifts are corrected by realignment: the read side either repeats the current sample for a block of reads (fill too low) or jumps its pointer forward by a block (fill too high). While the audio is quiet, the block uses long realignments whenever the fill leaves the soft band, so the correction cannot be heard. While the audio is loud, it uses short realignments and only at the hard limits. Each realignment raises a one-cycle duplicate or skip strobe.

The read-side controller has three states:
- `ST_PRIME`: after reset; the controller outputs zeros and holds its pointer.
- `ST_RUN`: normal reading.
- `ST_REPEAT`: a repeat block is in progress.

Its transitions are:
- `PRIME->RUN`: the fill reaches half depth.
- `RUN->REPEAT`: a repeat is decided on a request.
- `REPEAT->RUN`: the last repeat request is consumed.
- A hop is performed inside `ST_RUN` in a single request, so it needs no state of its own.

Top module: `audio_slip_buffer`

## Requirements
- R1: After reset the read outputs are zero and the read pointer holds until the fill level first reaches DEPTH/2. No real sample appears before DEPTH/2 words have been written.
- R2: In normal running, each read request returns the next written sample in write order. The sample is packed {left,right} with 16 bits per channel, and it appears on the outputs one read-clock cycle after the request.
- R3: When the audio is quiet, a fill below SOFT_LO starts a repeat of BIG_LEN reads. A fill above SOFT_HI makes the pointer hop forward by BIG_LEN samples, discarding them.
- R4: When the audio is not quiet, a fill at or below HARD_LO starts a repeat of SMALL_LEN reads. During the repeat the output holds its last value.
- R5: When the audio is not quiet, a fill at or above HARD_HI makes the pointer hop forward by SMALL_LEN samples. The sample returned by that request is the one SMALL_LEN places beyond the next in order.
- R6: Each repeat raises dup_pulse, and each hop raises skip_pulse. The pulse lasts one read-clock cycle on the request that starts the realignment, and the two are never high together.
- R7: On every running read request, trim_up is set to (fill > SOFT_HI) and trim_dn is set to (fill < SOFT_LO). Each holds until the next request, and the two are never high together.
- R8: While a repeat is in progress, no new limit check is made: there is no further pulse, no hop and no pointer advance until the repeat ends.
- R9: The audio is quiet when both channels, taken as signed values, have a magnitude below SIL_TH for SIL_LEN consecutive samples read from the buffer. The quiet output shows this state.
- R10: The write pointer crosses to the read clock in Gray code, changing at most one bit per write-clock cycle, so no word is lost or reordered in transit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| wr_rst_n | input | 1 | Write-side active-low reset |
| wr_stb | input | 1 | Write sample strobe |
| wr_left | input | SW | Left sample to write |
| wr_right | input | SW | Right sample to write |
| rd_clk | input | 1 | Read-side clock |
| rd_rst_n | input | 1 | Read-side active-low reset |
| rd_req | input | 1 | Read sample request |
| rd_left | output | SW | Left sample read |
| rd_right | output | SW | Right sample read |
| dup_pulse | output | 1 | One cycle per repeat block |
| skip_pulse | output | 1 | One cycle per hop |
| trim_up | output | 1 | Speed-up trim, one sample period |
| trim_dn | output | 1 | Slow-down trim, one sample period |
| quiet | output | 1 | Quiet-audio status |
| fill_level | output | AW+1 | Read-domain fill level |

## Verification
On every cycle, the assertions check several rules:
- the duplicate and skip strobes, and the two trim outputs, are mutually exclusive;
- the output word is frozen while a repeat runs, with no hop inside it;
- the read side stays at zero during priming;
- the fill never exceeds the depth;
- the Gray pointer changes by at most one bit per cycle.

Other behaviour needs the bench's rate-mismatch scenarios, with loud and quiet streams written fast and slow:
- that each output word is the correct next written word, or a legitimate repeat or discard;
- that block lengths follow the quiet state;
- that all four realignment kinds and both trim directions actually occur.

// File: rtl/ab_pkg.sv
package ab_pkg;
    typedef enum logic [1:0] {
        ST_PRIME  = 2'd0,
        ST_RUN    = 2'd1,
        ST_REPEAT = 2'd2
    } slip_state_t;
endpackage

// File: rtl/ab_ptr_sync.sv
module ab_ptr_sync #(
    parameter int W = 11
) (
    input  logic         src_clk,
    input  logic         src_rst_n,
    input  logic [W-1:0] src_bin,
    input  logic         dst_clk,
    input  logic         dst_rst_n,
    output logic [W-1:0] dst_bin
);
    logic [W-1:0] gray_q;
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    always_ff @(posedge src_clk or negedge src_rst_n) begin
        if (!src_rst_n) gray_q <= '0;
        else            gray_q <= src_bin ^ (src_bin >> 1);
    end

    always_ff @(posedge dst_clk or negedge dst_rst_n) begin
        if (!dst_rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= gray_q;
            sync_q <= meta_q;
        end
    end

    always_comb begin
        dst_bin[W-1] = sync_q[W-1];
        for (int i = W - 2; i >= 0; i--) begin
            dst_bin[i] = dst_bin[i+1] ^ sync_q[i];
        end
    end

    // R10: the crossing value moves by at most one bit per source cycle
    assert_gray_step_R10: assert property (@(posedge src_clk) disable iff (!src_rst_n)
        $countones(gray_q ^ $past(gray_q)) <= 1);
endmodule

// File: rtl/ab_silence_det.sv
module ab_silence_det #(
    parameter int SW      = 16,
    parameter int SIL_TH  = 16,
    parameter int SIL_LEN = 256
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          take,
    input  logic [2*SW-1:0] sample,
    output logic          silent
);
    localparam int CW = $clog2(SIL_LEN + 1);
    localparam logic signed [SW-1:0] TH_P  = SW'(SIL_TH);
    localparam logic signed [SW-1:0] NTH_P = -SW'(SIL_TH);
    localparam logic [CW-1:0] LEN_P = CW'(SIL_LEN);

    logic signed [SW-1:0] ch_l, ch_r;
    logic                 small_now;
    logic [CW-1:0]        run_cnt;

    always_comb begin
        ch_l = sample[2*SW-1:SW];
        ch_r = sample[SW-1:0];
        small_now = (ch_l < TH_P) && (ch_l > NTH_P) && (ch_r < TH_P) && (ch_r > NTH_P);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          run_cnt <= '0;
        else if (take) begin
            if (!small_now)            run_cnt <= '0;
            else if (run_cnt != LEN_P) run_cnt <= run_cnt + 1'b1;
        end
    end

    assign silent = (run_cnt == LEN_P);

    // R9: quiet can only begin right after a sample was taken from the buffer
    assert_quiet_after_take_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(silent) |-> $past(take));
endmodule

// File: rtl/ab_slip_ctrl.sv
module ab_slip_ctrl
    import ab_pkg::*;
#(
    parameter int DEPTH     = 1024,
    parameter int PW        = 11,
    parameter int DW        = 32,
    parameter int HARD_LO   = 64,
    parameter int HARD_HI   = 960,
    parameter int SOFT_LO   = 448,
    parameter int SOFT_HI   = 576,
    parameter int BIG_LEN   = 480,
    parameter int SMALL_LEN = 96
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_req,
    input  logic [PW-1:0] wr_ptr_sync,
    input  logic          silent,
    input  logic [DW-1:0] mem_rdata,
    output logic [PW-1:0] rd_addr,
    output logic          take,
    output logic [PW-1:0] fill,
    output logic [DW-1:0] rd_data,
    output logic          dup_o,
    output logic          skip_o,
    output logic          trim_up,
    output logic          trim_dn
);
    localparam int CW = $clog2(BIG_LEN + 1);
    localparam logic [PW-1:0] HALF_P = PW'(DEPTH / 2);
    localparam logic [PW-1:0] HLO_P  = PW'(HARD_LO);
    localparam logic [PW-1:0] HHI_P  = PW'(HARD_HI);
    localparam logic [PW-1:0] SLO_P  = PW'(SOFT_LO);
    localparam logic [PW-1:0] SHI_P  = PW'(SOFT_HI);
    localparam logic [PW-1:0] BIGP   = PW'(BIG_LEN);
    localparam logic [PW-1:0] SMLP   = PW'(SMALL_LEN);
    localparam logic [CW-1:0] BIGC   = CW'(BIG_LEN - 1);
    localparam logic [CW-1:0] SMLC   = CW'(SMALL_LEN - 1);

    slip_state_t   state, state_nx;
    logic [PW-1:0] rd_ptr;
    logic [CW-1:0] rep_cnt;
    logic          req_run, want_rep, want_hop, rep_now, hop_now;

    always_comb begin
        fill     = wr_ptr_sync - rd_ptr;
        req_run  = rd_req && (state == ST_RUN);
        want_rep = silent ? (fill < SLO_P) : (fill <= HLO_P);
        want_hop = silent ? (fill > SHI_P) : (fill >= HHI_P);
        rep_now  = req_run && want_rep;
        hop_now  = req_run && want_hop && !want_rep;
        rd_addr  = rd_ptr + (hop_now ? (silent ? BIGP : SMLP) : '0);
        take     = req_run && !rep_now;
        state_nx = state;
        unique case (state)
            ST_PRIME:  if (fill >= HALF_P) state_nx = ST_RUN;
            ST_RUN:    if (rep_now) state_nx = ST_REPEAT;
            ST_REPEAT: if (rd_req && rep_cnt == CW'(1)) state_nx = ST_RUN;
            default:   state_nx = ST_PRIME;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_PRIME;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_ptr  <= '0;
            rep_cnt <= '0;
            rd_data <= '0;
            dup_o   <= 1'b0;
            skip_o  <= 1'b0;
            trim_up <= 1'b0;
            trim_dn <= 1'b0;
        end else begin
            dup_o  <= 1'b0;
            skip_o <= 1'b0;
            if (rd_req && state != ST_PRIME) begin
                trim_up <= (fill > SHI_P);
                trim_dn <= (fill < SLO_P);
            end
            if (rep_now) begin
                dup_o   <= 1'b1;
                rep_cnt <= silent ? BIGC : SMLC;
            end else if (take) begin
                rd_data <= mem_rdata;
                rd_ptr  <= rd_addr + 1'b1;
                skip_o  <= hop_now;
            end else if (rd_req && state == ST_REPEAT) begin
                rep_cnt <= rep_cnt - 1'b1;
            end
        end
    end

    // R1: priming keeps the output silent and the pointer parked
    assert_prime_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PRIME) |-> (rd_data == '0 && rd_ptr == '0));
    // R2: the fill seen by the read side never exceeds the storage
    assert_fill_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= PW'(DEPTH));
    // R6: a realignment is either a repeat or a hop, never both
    assert_dup_skip_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(dup_o && skip_o));
    // R7: trim directions are exclusive
    assert_trim_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(trim_up && trim_dn));
    // R8: inside a repeat the word is frozen and nothing is skipped
    assert_repeat_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_REPEAT) |=> ($stable(rd_data) && !skip_o));
endmodule

// File: rtl/audio_slip_buffer.sv
module audio_slip_buffer #(
    parameter int DEPTH     = 1024,
    parameter int SW        = 16,
    parameter int HARD_LO   = 64,
    parameter int HARD_HI   = 960,
    parameter int SOFT_LO   = 448,
    parameter int SOFT_HI   = 576,
    parameter int BIG_LEN   = 480,
    parameter int SMALL_LEN = 96,
    parameter int SIL_TH    = 16,
    parameter int SIL_LEN   = 256,
    localparam int AW = $clog2(DEPTH),
    localparam int PW = AW + 1,
    localparam int DW = 2 * SW
) (
    input  logic          wr_clk,
    input  logic          wr_rst_n,
    input  logic          wr_stb,
    input  logic [SW-1:0] wr_left,
    input  logic [SW-1:0] wr_right,
    input  logic          rd_clk,
    input  logic          rd_rst_n,
    input  logic          rd_req,
    output logic [SW-1:0] rd_left,
    output logic [SW-1:0] rd_right,
    output logic          dup_pulse,
    output logic          skip_pulse,
    output logic          trim_up,
    output logic          trim_dn,
    output logic          quiet,
    output logic [PW-1:0] fill_level
);
    logic [DW-1:0] mem [DEPTH];
    logic [PW-1:0] wr_ptr, wr_ptr_rd, rd_addr;
    logic [DW-1:0] mem_rdata, rd_word;
    logic          take;

    always_ff @(posedge wr_clk or negedge wr_rst_n) begin
        if (!wr_rst_n)   wr_ptr <= '0;
        else if (wr_stb) wr_ptr <= wr_ptr + 1'b1;
    end

    always_ff @(posedge wr_clk) begin
        if (wr_stb) mem[wr_ptr[AW-1:0]] <= {wr_left, wr_right};
    end

    assign mem_rdata = mem[rd_addr[AW-1:0]];

    ab_ptr_sync #(.W(PW)) u_sync (
        .src_clk   (wr_clk),
        .src_rst_n (wr_rst_n),
        .src_bin   (wr_ptr),
        .dst_clk   (rd_clk),
        .dst_rst_n (rd_rst_n),
        .dst_bin   (wr_ptr_rd)
    );

    ab_silence_det #(.SW(SW), .SIL_TH(SIL_TH), .SIL_LEN(SIL_LEN)) u_quiet (
        .clk    (rd_clk),
        .rst_n  (rd_rst_n),
        .take   (take),
        .sample (mem_rdata),
        .silent (quiet)
    );

    ab_slip_ctrl #(
        .DEPTH(DEPTH), .PW(PW), .DW(DW),
        .HARD_LO(HARD_LO), .HARD_HI(HARD_HI),
        .SOFT_LO(SOFT_LO), .SOFT_HI(SOFT_HI),
        .BIG_LEN(BIG_LEN), .SMALL_LEN(SMALL_LEN)
    ) u_ctrl (
        .clk         (rd_clk),
        .rst_n       (rd_rst_n),
        .rd_req      (rd_req),
        .wr_ptr_sync (wr_ptr_rd),
        .silent      (quiet),
        .mem_rdata   (mem_rdata),
        .rd_addr     (rd_addr),
        .take        (take),
        .fill        (fill_level),
        .rd_data     (rd_word),
        .dup_o       (dup_pulse),
        .skip_o      (skip_pulse),
        .trim_up     (trim_up),
        .trim_dn     (trim_dn)
    );

    assign rd_left  = rd_word[DW-1:SW];
    assign rd_right = rd_word[SW-1:0];
endmodule

// File: tb/tb_audio_slip_buffer.sv
`timescale 1ns/1ps
module tb_audio_slip_buffer;
    localparam int DEPTH = 64, SW = 16, HLO = 8, HHI = 56, SLO = 28, SHI = 36;
    localparam int BIG = 24, SML = 6, STH = 16, SLEN = 16;

    logic wr_clk = 0, rd_clk = 0, wr_rst_n = 0, rd_rst_n = 0;
    logic wr_stb = 0, rd_req = 0;
    logic [SW-1:0] wr_left = '0, wr_right = '0, rd_left, rd_right;
    logic dup_pulse, skip_pulse, trim_up, trim_dn, quiet;
    logic [6:0] fill_level;

    audio_slip_buffer #(.DEPTH(DEPTH), .SW(SW), .HARD_LO(HLO), .HARD_HI(HHI),
        .SOFT_LO(SLO), .SOFT_HI(SHI), .BIG_LEN(BIG), .SMALL_LEN(SML),
        .SIL_TH(STH), .SIL_LEN(SLEN)) dut (.*);

    real wr_half = 4.75;
    always #5 rd_clk = ~rd_clk;
    always #(wr_half) wr_clk = ~wr_clk;

    int tests = 0, fails = 0, writes = 0;
    bit quiet_src = 0, done = 0;
    logic [31:0] q[$];

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // writer: one sample every 8 write clocks, identity carried in the values
    initial begin
        int seq = 0;
        wait (wr_rst_n);
        while (!done) begin
            repeat (7) @(negedge wr_clk);
            wr_stb = 1;
            if (quiet_src) begin
                wr_left  = SW'((seq % 8) - 4);
                wr_right = SW'(3 - (seq % 7));
            end else begin
                wr_left  = SW'(1000 + (seq % 20000));
                wr_right = SW'(-(1000 + (seq % 20000)));
            end
            q.push_back({wr_left, wr_right});
            writes++;
            seq++;
            @(negedge wr_clk);
            wr_stb = 0;
        end
    end

    initial begin
        repeat (190000) @(posedge rd_clk);
        fails++; tests++;
        $display("FAIL watchdog actual=%0d expected=%0d", 190000, 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    bit primed = 0, msil;
    int rep_left = 0, scnt = 0, len;
    int n_srep = 0, n_brep = 0, n_shop = 0, n_bhop = 0, n_up = 0, n_dn = 0;
    logic [31:0] last = '0, exp, obs;

    task automatic read_phase(input int n, input int phase);
        for (int i = 0; i < n; i++) begin
            @(negedge rd_clk) rd_req = 1;
            @(negedge rd_clk) rd_req = 0;
            obs  = {rd_left, rd_right};
            msil = (scnt == SLEN);
            len  = msil ? BIG : SML;
            chk(!(trim_up && trim_dn), "R7 trims exclusive", {trim_up, trim_dn}, 0);
            chk(!(dup_pulse && skip_pulse), "R6 dup/skip exclusive", {dup_pulse, skip_pulse}, 0);
            if (phase == 0 && trim_up) n_up++;
            if (phase == 1 && trim_dn) n_dn++;
            if (!primed && obs == 0 && !dup_pulse && !skip_pulse) begin
                chk(1, "R1 zero while priming", obs, 0);
            end else if (!primed) begin
                primed = 1;
                chk(writes >= DEPTH / 2, "R1 prime at half depth", writes, DEPTH / 2);
                exp = q.pop_front();
                chk(obs == exp, "R1 first sample", obs, exp);
                last = exp;
                scnt = 0;
            end else if (rep_left > 0) begin
                chk(obs == last && !dup_pulse && !skip_pulse, "R8 repeat in progress", obs, last);
                rep_left--;
            end else if (dup_pulse) begin
                chk(obs == last, msil ? "R3 big repeat hold" : "R4 small repeat hold", obs, last);
                rep_left = len - 1;
                if (msil) n_brep++; else n_srep++;
            end else begin
                if (skip_pulse) begin
                    for (int k = 0; k < len; k++) void'(q.pop_front());
                    if (msil) n_bhop++; else n_shop++;
                end
                exp = q.pop_front();
                chk(obs == exp, skip_pulse ? (msil ? "R3 big hop" : "R5 small hop") : "R2,R10 in-order sample", obs, exp);
                last = exp;
                if ($signed(exp[31:16]) < STH && $signed(exp[31:16]) > -STH &&
                    $signed(exp[15:0]) < STH && $signed(exp[15:0]) > -STH) begin
                    if (scnt < SLEN) scnt++;
                end else scnt = 0;
                chk(quiet == (scnt == SLEN), "R9 quiet status", quiet, (scnt == SLEN));
            end
            @(negedge rd_clk);
            chk(!dup_pulse && !skip_pulse, "R6 one-cycle pulse", {dup_pulse, skip_pulse}, 0);
            repeat (5) @(negedge rd_clk);
        end
    endtask

    initial begin
        repeat (4) @(negedge rd_clk);
        chk(rd_left == 0 && rd_right == 0 && !dup_pulse && !skip_pulse && !trim_up && !trim_dn,
            "R1 reset state", {rd_left, rd_right}, 0);
        wr_rst_n = 1; rd_rst_n = 1;
        wr_half = 4.75; quiet_src = 0; read_phase(1200, 0);
        wr_half = 5.25; quiet_src = 0; read_phase(1500, 1);
        wr_half = 4.75; quiet_src = 1; read_phase(800, 2);
        wr_half = 5.25; quiet_src = 1; read_phase(800, 3);
        done = 1;
        chk(n_shop > 0, "R5 small hops seen", n_shop, 1);
        chk(n_srep > 0, "R4 small repeats seen", n_srep, 1);
        chk(n_bhop > 0, "R3 big hops seen", n_bhop, 1);
        chk(n_brep > 0, "R3 big repeats seen", n_brep, 1);
        chk(n_up > 0, "R7 speed-up trim seen", n_up, 1);
        chk(n_dn > 0, "R7 slow-down trim seen", n_dn, 1);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule